// File: doc/BRIEF.md
# GPIO Port Register Bank with Bit-Operation Aliases

This block is the software-visible register file of a 16-bit general-purpose I/O port. A bus master reaches it over a plain single-cycle bus with an address, separate write and read strobes, an access-size code, 16-bit write data and 16-bit read data. The bank holds eight registers: the port data value, two interrupt enable masks (A and B), and the direction, polarity, edge-mode, both-edge and input-enable controls. Every register is exported as a parallel output so that the pin interrupt logic and the pad control can use it.

The data register and the two mask registers each have three extra write addresses. One clears bits, one sets bits and one toggles bits, in each case only where the write data holds a 1. Software can therefore change single bits without a read-modify-write sequence. A read at any of these extra addresses returns the register behind it. The pin-side logic can load individual bits of the data register directly. When that load meets a bus write to the data register in the same cycle, the bus write takes precedence. An access at an unmapped offset, or one of any width other than 16 bits, changes nothing and raises a one-cycle error pulse.

Top module: `gpio_regbank`

## Requirements
- R1: While rst_ni is low and right after it is released, every register output, rdata_o and err_o are zero.
- R2: A valid write at a base offset replaces the whole register. The base offsets are 0x00 data, 0x10 mask A, 0x20 mask B, 0x30 direction, 0x34 polarity, 0x38 edge, 0x3C both-edge and 0x40 input-enable. The new value is visible on the register output after the clock edge that samples the write.
- R3: A write at base+0x04 of data, mask A or mask B clears each target bit whose write-data bit is 1 and keeps the others.
- R4: A write at base+0x08 of data, mask A or mask B ORs the write data into the target.
- R5: A write at base+0x0C of data, mask A or mask B XORs the write data into the target.
- R6: A valid read presents its data on rdata_o in the cycle after rd_i is sampled. The value is the register as it stood before any write sampled at the same edge. Reads at base, +0x04, +0x08 and +0x0C of data, mask A and mask B all return the underlying register. In a cycle that follows no valid read, rdata_o is zero.
- R7: size_i codes the access width as 0 for 8 bits, 1 for 16 bits, 2 for 32 bits, with 3 reserved. Only code 1 is accepted. Any other code with wr_i or rd_i raises err_o for exactly the following cycle, changes no register, and returns zero read data.
- R8: An offset with either low address bit set, or an offset above 0x40, is unmapped. An access there raises err_o for the following cycle, changes no register, and reads as zero.
- R9: Each data bit whose pin_we_i bit is 1 takes the matching pin_val_i bit at the next clock edge. Bits with pin_we_i at 0 hold their value.
- R10: If a valid write at any of the four data offsets is sampled in the same cycle as a pin update, the bus result is stored and the whole pin update is discarded. A pin update alongside a write to any other register still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte offset of the access |
| size_i | input | 2 | Access width code (1 = 16 bit) |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Registered read data |
| err_o | output | 1 | One-cycle pulse for an invalid access |
| pin_we_i | input | DW | Per-bit load enable from the pin side |
| pin_val_i | input | DW | Pin-side values for the data register |
| data_o | output | DW | Data register |
| mask_a_o | output | DW | Interrupt mask A |
| mask_b_o | output | DW | Interrupt mask B |
| dir_o | output | DW | Direction register |
| polar_o | output | DW | Polarity register |
| edge_o | output | DW | Edge-mode register |
| both_o | output | DW | Both-edge register |
| inen_o | output | DW | Input-enable register |

## Verification
The bit operations use overlapping patterns. Where a plain write and its clear, set or toggle alias would give the same result, the patterns tell them apart, and a swap between the set and toggle paths shows up on bits that are already 1. Reads sweep every alias of the three aliased registers, so a decoder that maps an alias to the wrong target is caught. A read and a write on one address in the same cycle show whether read data is taken before or after the update. Pin loads are tried alone, together with a mask write, and together with base and clear writes to data, which isolates the priority rule. A long phase of random addresses, sizes and pin activity then mixes valid, misaligned, out-of-range and wrong-width accesses against the reference model.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;
  localparam int unsigned NUM_REGS    = 8;
  localparam int unsigned NUM_ALIASED = 3;
  localparam int unsigned PLAIN_BASE  = NUM_ALIASED * 4;
  localparam int unsigned NUM_SLOTS   = PLAIN_BASE + NUM_REGS - NUM_ALIASED;
  localparam logic [1:0]  ACC_16      = 2'd1;

  typedef enum logic [1:0] {
    OP_WRITE  = 2'd0,
    OP_CLEAR  = 2'd1,
    OP_SET    = 2'd2,
    OP_TOGGLE = 2'd3
  } reg_op_e;

  typedef enum logic [3:0] {
    SEL_DATA   = 4'd0,
    SEL_MASK_A = 4'd1,
    SEL_MASK_B = 4'd2,
    SEL_DIR    = 4'd3,
    SEL_POLAR  = 4'd4,
    SEL_EDGE   = 4'd5,
    SEL_BOTH   = 4'd6,
    SEL_INEN   = 4'd7
  } reg_sel_e;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  output logic              valid_o,
  output reg_sel_e          sel_o,
  output reg_op_e           op_o
);
  localparam int unsigned SLOT_W = ADDR_W - 2;
  localparam int unsigned PLAIN_OFS = PLAIN_BASE - NUM_ALIASED;

  logic [SLOT_W-1:0] slot;
  assign slot = addr_i[ADDR_W-1:2];

  always_comb begin
    valid_o = (addr_i[1:0] == 2'b00) && (size_i == ACC_16) && (32'(slot) < NUM_SLOTS);
    if (32'(slot) < PLAIN_BASE) begin
      // four slots per aliased register: base, clear, set, toggle
      sel_o = reg_sel_e'(4'(slot >> 2));
      op_o  = reg_op_e'(slot[1:0]);
    end else begin
      sel_o = reg_sel_e'(4'(slot - SLOT_W'(PLAIN_OFS)));
      op_o  = OP_WRITE;
    end
  end
endmodule

// File: rtl/gpio_reg_cell.sv
module gpio_reg_cell
  import gpio_regbank_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_we_i,
  input  reg_op_e       op_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] pin_we_i,
  input  logic [DW-1:0] pin_val_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] q, nxt;

  always_comb begin
    nxt = q;
    if (bus_we_i) begin
      unique case (op_i)
        OP_WRITE:  nxt = wdata_i;
        OP_CLEAR:  nxt = q & ~wdata_i;
        OP_SET:    nxt = q | wdata_i;
        OP_TOGGLE: nxt = q ^ wdata_i;
        default:   nxt = q;
      endcase
    end else begin
      // pin side only loads when the bus leaves this register alone
      nxt = (q & ~pin_we_i) | (pin_val_i & pin_we_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= nxt;
  end

  assign q_o = q;
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_regbank_pkg::*;
#(
  parameter int unsigned DW     = 16,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              err_o,
  input  logic [DW-1:0]     pin_we_i,
  input  logic [DW-1:0]     pin_val_i,
  output logic [DW-1:0]     data_o,
  output logic [DW-1:0]     mask_a_o,
  output logic [DW-1:0]     mask_b_o,
  output logic [DW-1:0]     dir_o,
  output logic [DW-1:0]     polar_o,
  output logic [DW-1:0]     edge_o,
  output logic [DW-1:0]     both_o,
  output logic [DW-1:0]     inen_o
);
  logic     acc_ok, wr_ok, rd_ok;
  reg_sel_e sel;
  reg_op_e  op;
  logic [NUM_REGS-1:0][DW-1:0] regs_q;
  logic [DW-1:0] rd_mux, rdata_q;
  logic          err_q;

  gpio_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i  (addr_i),
    .size_i  (size_i),
    .valid_o (acc_ok),
    .sel_o   (sel),
    .op_o    (op)
  );

  assign wr_ok = wr_i & acc_ok;
  assign rd_ok = rd_i & acc_ok;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic hit;
    assign hit = wr_ok && (sel == reg_sel_e'(4'(g)));
    if (g == int'(SEL_DATA)) begin : g_pin
      gpio_reg_cell #(.DW(DW)) u_cell (
        .clk_i, .rst_ni,
        .bus_we_i  (hit),
        .op_i      (op),
        .wdata_i   (wdata_i),
        .pin_we_i  (pin_we_i),
        .pin_val_i (pin_val_i),
        .q_o       (regs_q[g])
      );
    end else begin : g_bus
      gpio_reg_cell #(.DW(DW)) u_cell (
        .clk_i, .rst_ni,
        .bus_we_i  (hit),
        .op_i      (op),
        .wdata_i   (wdata_i),
        .pin_we_i  ('0),
        .pin_val_i ('0),
        .q_o       (regs_q[g])
      );
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < int'(NUM_REGS); i++) begin
      if (sel == reg_sel_e'(4'(i))) rd_mux = regs_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= rd_ok ? rd_mux : '0;
      err_q   <= (wr_i | rd_i) & ~acc_ok;
    end
  end

  assign rdata_o  = rdata_q;
  assign err_o    = err_q;
  assign data_o   = regs_q[SEL_DATA];
  assign mask_a_o = regs_q[SEL_MASK_A];
  assign mask_b_o = regs_q[SEL_MASK_B];
  assign dir_o    = regs_q[SEL_DIR];
  assign polar_o  = regs_q[SEL_POLAR];
  assign edge_o   = regs_q[SEL_EDGE];
  assign both_o   = regs_q[SEL_BOTH];
  assign inen_o   = regs_q[SEL_INEN];
endmodule

// File: rtl/gpio_regbank_chk.sv
module gpio_regbank_chk #(
  parameter int unsigned DW     = 16,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [1:0]        size_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [DW-1:0]     wdata_i,
  input logic [DW-1:0]     pin_we_i,
  input logic [DW-1:0]     rdata_o,
  input logic              err_o,
  input logic [DW-1:0]     data_o,
  input logic [DW-1:0]     mask_a_o,
  input logic [DW-1:0]     mask_b_o,
  input logic [DW-1:0]     dir_o
);
  localparam logic [ADDR_W-1:0] OFS_DATA  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_MA_CL = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] OFS_MB_ST = ADDR_W'(8'h28);
  localparam logic [ADDR_W-1:0] OFS_DIR   = ADDR_W'(8'h30);

  // R2
  dir_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_i && size_i == 2'd1 && addr_i == OFS_DIR) |-> dir_o == $past(wdata_i));

  // R3
  mask_a_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_i && size_i == 2'd1 && addr_i == OFS_MA_CL) |-> (mask_a_o & $past(wdata_i)) == '0);

  // R4
  mask_b_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_i && size_i == 2'd1 && addr_i == OFS_MB_ST) |-> (mask_b_o & $past(wdata_i)) == $past(wdata_i));

  // R6
  idle_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_i) |-> rdata_o == '0);

  // R7
  err_no_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ($stable(mask_a_o) && $stable(mask_b_o) && $stable(dir_o)));

  // R8
  err_rdata_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> rdata_o == '0);

  // R10
  bus_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_i && size_i == 2'd1 && addr_i == OFS_DATA && (|pin_we_i)) |-> data_o == $past(wdata_i));
endmodule

bind gpio_regbank gpio_regbank_chk #(.DW(DW), .ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .size_i   (size_i),
  .wr_i     (wr_i),
  .rd_i     (rd_i),
  .wdata_i  (wdata_i),
  .pin_we_i (pin_we_i),
  .rdata_o  (rdata_o),
  .err_o    (err_o),
  .data_o   (data_o),
  .mask_a_o (mask_a_o),
  .mask_b_o (mask_b_o),
  .dir_o    (dir_o)
);

// File: tb/tb_gpio_regbank.sv
module tb_gpio_regbank;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr = '0;
  logic [1:0]  size = 2'd1;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] wdata = '0, pin_we = '0, pin_val = '0;
  logic [15:0] rdata, data, mask_a, mask_b, dir, polar, edge_r, both, inen;
  logic        err;

  int checks = 0;
  int failures = 0;
  string cur_tag = "R1";

  logic [15:0] m [8];
  logic [15:0] exp_rdata = '0;
  logic        exp_err = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  gpio_regbank dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .size_i(size),
    .wr_i(wr), .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata), .err_o(err),
    .pin_we_i(pin_we), .pin_val_i(pin_val),
    .data_o(data), .mask_a_o(mask_a), .mask_b_o(mask_b), .dir_o(dir),
    .polar_o(polar), .edge_o(edge_r), .both_o(both), .inen_o(inen)
  );

  task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", cur_tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check("data",   data,   m[0]);
    check("mask_a", mask_a, m[1]);
    check("mask_b", mask_b, m[2]);
    check("dir",    dir,    m[3]);
    check("polar",  polar,  m[4]);
    check("edge",   edge_r, m[5]);
    check("both",   both,   m[6]);
    check("inen",   inen,   m[7]);
    check("rdata",  rdata,  exp_rdata);
    check("err",    {15'd0, err}, {15'd0, exp_err});
  endtask

  // behavioural reference: one call per clock edge
  task automatic model_step();
    int slot, tgt, op;
    bit ok, data_hit;
    slot = int'(addr) / 4;
    ok = (addr[1:0] == 2'b00) && (size == 2'd1) && (slot <= 16);
    tgt = (slot < 12) ? slot / 4 : slot - 9;
    op  = (slot < 12) ? slot % 4 : 0;
    exp_err   = (wr || rd) && !ok;
    exp_rdata = (rd && ok) ? m[tgt] : 16'h0000;
    data_hit = 0;
    if (wr && ok) begin
      case (op)
        0: m[tgt] = wdata;
        1: m[tgt] = m[tgt] & ~wdata;
        2: m[tgt] = m[tgt] | wdata;
        default: m[tgt] = m[tgt] ^ wdata;
      endcase
      if (tgt == 0) data_hit = 1;
    end
    if (!data_hit) m[0] = (m[0] & ~pin_we) | (pin_val & pin_we);
  endtask

  task automatic cyc(input bit w, input bit r, input logic [7:0] a, input logic [1:0] s,
                     input logic [15:0] d, input logic [15:0] pwe, input logic [15:0] pv,
                     input string tag);
    @(negedge clk);
    wr = w; rd = r; addr = a; size = s; wdata = d; pin_we = pwe; pin_val = pv;
    cur_tag = tag;
    @(posedge clk);
    model_step();
    #1;
    compare_all();
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [15:0] d, input string tag);
    cyc(1, 0, a, 2'd1, d, '0, '0, tag);
  endtask

  task automatic bus_rd(input logic [7:0] a, input string tag);
    cyc(0, 1, a, 2'd1, '0, '0, '0, tag);
  endtask

  initial begin
    #(CLK_P * 150000);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m[i] = '0;
    // R1 reset state
    cur_tag = "R1";
    #(CLK_P * 2 + 1);
    compare_all();
    @(negedge clk);
    rst_ni = 1'b1;
    cyc(0, 0, 8'h00, 2'd1, '0, '0, '0, "R1");

    // R2 base writes
    bus_wr(8'h00, 16'hA5A5, "R2");
    bus_wr(8'h10, 16'h1234, "R2");
    bus_wr(8'h20, 16'h00FF, "R2");
    bus_wr(8'h30, 16'hF00F, "R2");
    bus_wr(8'h34, 16'h0F0F, "R2");
    bus_wr(8'h38, 16'h3333, "R2");
    bus_wr(8'h3C, 16'h5555, "R2");
    bus_wr(8'h40, 16'hAAAA, "R2");

    // R6 reads through every alias
    for (int a = 0; a < 12; a++) bus_rd(8'(a * 4), "R6");
    bus_rd(8'h30, "R6");
    bus_rd(8'h3C, "R6");
    bus_rd(8'h40, "R6");

    // R3 clear aliases
    bus_wr(8'h04, 16'h00F0, "R3");
    bus_wr(8'h14, 16'hFF00, "R3");
    bus_wr(8'h24, 16'h000F, "R3");
    // R4 set aliases
    bus_wr(8'h08, 16'h0F00, "R4");
    bus_wr(8'h18, 16'h8001, "R4");
    bus_wr(8'h28, 16'hF001, "R4");
    // R5 toggle aliases
    bus_wr(8'h0C, 16'hFFFF, "R5");
    bus_wr(8'h1C, 16'h00FF, "R5");
    bus_wr(8'h2C, 16'h0F0F, "R5");
    bus_rd(8'h0C, "R6");
    bus_rd(8'h18, "R6");
    bus_rd(8'h24, "R6");

    // R6 read and write on one address in one cycle
    cyc(1, 1, 8'h30, 2'd1, 16'h1111, '0, '0, "R6");
    cyc(1, 1, 8'h1C, 2'd1, 16'hFFFF, '0, '0, "R6");
    bus_rd(8'h30, "R6");

    // R7 wrong widths
    cyc(1, 0, 8'h30, 2'd0, 16'hDEAD, '0, '0, "R7");
    cyc(1, 0, 8'h30, 2'd2, 16'hBEEF, '0, '0, "R7");
    cyc(1, 0, 8'h10, 2'd3, 16'h0000, '0, '0, "R7");
    cyc(0, 1, 8'h00, 2'd2, 16'h0000, '0, '0, "R7");
    bus_rd(8'h30, "R7");

    // R8 unmapped offsets
    cyc(1, 0, 8'h31, 2'd1, 16'hFFFF, '0, '0, "R8");
    cyc(1, 0, 8'h44, 2'd1, 16'hFFFF, '0, '0, "R8");
    cyc(1, 0, 8'hFC, 2'd1, 16'hFFFF, '0, '0, "R8");
    cyc(0, 1, 8'h46, 2'd1, 16'h0000, '0, '0, "R8");
    cyc(0, 1, 8'h12, 2'd1, 16'h0000, '0, '0, "R8");

    // R9 pin loads
    cyc(0, 0, 8'h00, 2'd1, '0, 16'h00FF, 16'h5A5A, "R9");
    cyc(0, 0, 8'h00, 2'd1, '0, 16'hF000, 16'hFFFF, "R9");
    cyc(1, 0, 8'h10, 2'd1, 16'h0042, 16'h0F00, 16'h0000, "R9");
    bus_rd(8'h00, "R9");

    // R10 bus write to data beats pin load
    cyc(1, 0, 8'h04, 2'd1, 16'h0001, 16'hFFFF, 16'hFFFF, "R10");
    cyc(1, 0, 8'h00, 2'd1, 16'h1357, 16'hFFFF, 16'h0000, "R10");
    cyc(1, 0, 8'h0C, 2'd1, 16'h00FF, 16'hFF00, 16'h0000, "R10");
    cyc(1, 0, 8'h3C, 2'd1, 16'h0000, 16'hFFFF, 16'h0000, "R10");

    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      bit w, r;
      logic [7:0] a;
      logic [1:0] s;
      w = ($urandom_range(0, 2) == 0);
      r = ($urandom_range(0, 2) == 0);
      a = ($urandom_range(0, 7) == 0) ? 8'($urandom_range(0, 255)) : 8'($urandom_range(0, 17) * 4);
      s = ($urandom_range(0, 5) == 0) ? 2'($urandom_range(0, 3)) : 2'd1;
      cyc(w, r, a, s, 16'($urandom), ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'h0,
          16'($urandom), "R6");
    end

    cyc(0, 0, 8'h00, 2'd1, '0, '0, '0, "R6");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule